// File: doc/BRIEF.md
# Paged Address Translator

This block turns a 32-bit virtual address from a processor into a physical address by looking up one entry in a single-level page table held in memory. The low 9 bits of the address are the byte offset inside a 512-byte page. The upper 23 bits form the virtual page number. Two configuration registers give the table's word address (the table base) and the number of entries in it (the table length).

Each request runs to completion before the next one is taken. The page number is first checked against the table length. If it is in range, the entry is fetched from the memory port and judged. When the access succeeds and sets a status bit that was clear, the updated entry is written back to the same memory word before the answer goes out. Every response carries a 2-bit outcome code and, on success, the physical address.

The controller is a state machine with six states. IDLE accepts a request and always moves to BOUND. BOUND goes to REPLY when the page number is out of range, and to FETCH otherwise. FETCH holds the read until the memory acknowledges it, then moves to JUDGE. JUDGE goes to STORE when the entry needs an update, and to REPLY otherwise. STORE holds the write until it is acknowledged, then moves to REPLY. REPLY presents the response for one cycle and returns to IDLE.

Top module: `page_xlate`

## Requirements
- R1: The virtual address splits into offset bits [8:0] and page number bits [31:9]. A successful response gives rsp_paddr = {entry bits [22:0], offset}, with the offset unchanged.
- R2: A page number greater than or equal to the table length returns outcome 1 (length fault) and rsp_paddr 0, and makes no memory access.
- R3: The entry is read from memory word address table base + page number, with the page number zero-extended.
- R4: An entry whose bit 31 (present) is clear returns outcome 2 (not resident) and rsp_paddr 0. The entry is not written.
- R5: A write access to an entry whose bit 30 (read-only) is set returns outcome 3 (protection fault) and rsp_paddr 0. The entry is not written.
- R6: A successful access sets bit 29 (referenced). A successful write also sets bit 28 (written-in). The updated entry is stored at the address it was read from, before the response is given.
- R7: When a successful access leaves all status bits unchanged, no memory write is made.
- R8: The outcome code is 0 for success, 1 for length, 2 for not resident and 3 for protection. rsp_valid is high for exactly one cycle per request.
- R9: While mem_req is high and mem_ack is low, mem_req stays high in the next cycle and mem_addr, mem_we and mem_wdata are stable.
- R10: After reset, req_ready is 1 and rsp_valid and mem_req are 0. req_ready is low from the cycle after a request is accepted until the response has been given.
- R11: A write on the configuration port with cfg_sel 0 loads the table base, and with cfg_sel 1 loads the table length. Requests that follow use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 selects the table length |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | Request is a write access |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | Outcome code |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address of the entry |
| mem_wdata | output | 32 | Updated entry to store |
| mem_ack | input | 1 | Memory has completed the access |
| mem_rdata | input | 32 | Entry read from memory, valid with mem_ack |

## Verification
The translation is driven with entries that each reach a different JUDGE outcome. One entry has its referenced bit clear, one has all status bits already set, one is a writable page hit by a write, one is read-only and hit by both a write and a read, and one is absent. This separates the cases that need a write-back from the cases that must leave memory untouched. Page numbers at the last legal index, at the table length, at the largest possible value, and with a length of zero exercise the boundary of the length check. Each of these also checks that no memory traffic happens on a length fault. Moving the table base shows that the lookup address follows the base register, and offsets of 0 and all-ones show that the offset passes through unchanged.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    typedef enum logic [1:0] {
        FLT_OK     = 2'd0,
        FLT_LEN    = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_PROT   = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BOUND,
        ST_FETCH,
        ST_JUDGE,
        ST_STORE,
        ST_REPLY
    } xl_state_e;

    // entry status bit positions (entry word is 32 bits)
    localparam int ENT_PRESENT = 31;
    localparam int ENT_RDONLY  = 30;
    localparam int ENT_REFD    = 29;
    localparam int ENT_WRTN    = 28;

endpackage

// File: rtl/pxu_cfg.sv
module pxu_cfg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] tbl_base,
    output logic [ADDR_W-1:0] tbl_len
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_base <= '0;
            tbl_len  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) tbl_len  <= cfg_wdata;
            else         tbl_base <= cfg_wdata;
        end
    end

endmodule

// File: rtl/pxu_judge.sv
module pxu_judge
    import pxu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 23,
    parameter int OFS_W   = 9,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input  logic [DATA_W-1:0] entry_i,
    input  logic              wr_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output fault_e            fault_o,
    output logic [DATA_W-1:0] entry_o,
    output logic              change_o,
    output logic [PA_W-1:0]   paddr_o
);

    logic present, rdonly;
    logic [DATA_W-1:0] set_mask;

    assign present = entry_i[ENT_PRESENT];
    assign rdonly  = entry_i[ENT_RDONLY];

    always_comb begin
        set_mask = '0;
        set_mask[ENT_REFD] = 1'b1;
        set_mask[ENT_WRTN] = wr_i;
    end

    always_comb begin
        if (!present) begin
            fault_o = FLT_ABSENT;
            entry_o = entry_i;
        end else if (wr_i && rdonly) begin
            fault_o = FLT_PROT;
            entry_o = entry_i;
        end else begin
            fault_o = FLT_OK;
            entry_o = entry_i | set_mask;
        end
    end

    assign change_o = (entry_o != entry_i);
    assign paddr_o  = {entry_i[FRAME_W-1:0], ofs_i};

endmodule

// File: rtl/pxu_ctrl.sv
module pxu_ctrl
    import pxu_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int OFS_W   = 9,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int PA_W    = 32,
    localparam int VPN_W  = VA_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] tbl_len,
    output logic [DATA_W-1:0] ent_q,
    output logic              wr_q,
    output logic [OFS_W-1:0]  ofs_q,
    input  fault_e            jdg_fault,
    input  logic [DATA_W-1:0] jdg_entry,
    input  logic              jdg_change,
    input  logic [PA_W-1:0]   jdg_paddr
);

    xl_state_e state_q, state_d;

    logic [VPN_W-1:0]  vpn_q;
    logic [DATA_W-1:0] upd_q;
    fault_e            flt_q;
    logic [PA_W-1:0]   pa_q;
    logic [ADDR_W-1:0] vpn_ext;
    logic              out_of_range;

    assign vpn_ext      = ADDR_W'(vpn_q);
    assign out_of_range = (vpn_ext >= tbl_len);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_BOUND;
            ST_BOUND: state_d = out_of_range ? ST_REPLY : ST_FETCH;
            ST_FETCH: if (mem_ack) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (jdg_fault == FLT_OK && jdg_change) state_d = ST_STORE;
                else                                   state_d = ST_REPLY;
            end
            ST_STORE: if (mem_ack) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q <= '0;
            ofs_q <= '0;
            wr_q  <= 1'b0;
            ent_q <= '0;
            upd_q <= '0;
            flt_q <= FLT_OK;
            pa_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    vpn_q <= req_vaddr[VA_W-1:OFS_W];
                    ofs_q <= req_vaddr[OFS_W-1:0];
                    wr_q  <= req_write;
                end
                ST_BOUND: if (out_of_range) begin
                    flt_q <= FLT_LEN;
                    pa_q  <= '0;
                end
                ST_FETCH: if (mem_ack) ent_q <= mem_rdata;
                ST_JUDGE: begin
                    flt_q <= jdg_fault;
                    pa_q  <= (jdg_fault == FLT_OK) ? jdg_paddr : '0;
                    upd_q <= jdg_entry;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_req   = 1'b1;
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_REPLY: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr  = tbl_base + vpn_ext;
    assign mem_wdata = upd_q;
    assign rsp_paddr = pa_q;
    assign rsp_fault = flt_q;

    // one response per request, a single cycle wide
    p_reply_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // memory access held steady until acknowledged
    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // out-of-range page goes straight to the reply, no memory cycle
    p_len_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOUND && out_of_range) |=> (!mem_req && rsp_valid
                                                   && rsp_fault == FLT_LEN));

    // a store always carries a changed entry
    p_store_changes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata != ent_q));

    // protection outcome only for write requests
    p_prot_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_PROT) |-> wr_q);

    // no new request while a response is outstanding
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import pxu_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int OFS_W   = 9,
    parameter int FRAME_W = 23,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic [ADDR_W-1:0] tbl_base, tbl_len;
    logic [DATA_W-1:0] ent_q, jdg_entry;
    logic              wr_q, jdg_change;
    logic [OFS_W-1:0]  ofs_q;
    fault_e            jdg_fault;
    logic [PA_W-1:0]   jdg_paddr;

    pxu_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .tbl_base  (tbl_base),
        .tbl_len   (tbl_len)
    );

    pxu_judge #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .OFS_W   (OFS_W)
    ) u_judge (
        .entry_i  (ent_q),
        .wr_i     (wr_q),
        .ofs_i    (ofs_q),
        .fault_o  (jdg_fault),
        .entry_o  (jdg_entry),
        .change_o (jdg_change),
        .paddr_o  (jdg_paddr)
    );

    pxu_ctrl #(
        .VA_W   (VA_W),
        .OFS_W  (OFS_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PA_W   (PA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_vaddr  (req_vaddr),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .tbl_base   (tbl_base),
        .tbl_len    (tbl_len),
        .ent_q      (ent_q),
        .wr_q       (wr_q),
        .ofs_q      (ofs_q),
        .jdg_fault  (jdg_fault),
        .jdg_entry  (jdg_entry),
        .jdg_change (jdg_change),
        .jdg_paddr  (jdg_paddr)
    );

endmodule

// File: tb/page_xlate_tb.sv
module page_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, rsp_valid, mem_req, mem_we;
    logic [31:0] rsp_paddr, mem_addr, mem_wdata;
    logic [1:0]  rsp_fault;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;   // 50 MHz

    page_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_vaddr(req_vaddr), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_rd = '0;
    logic [31:0] mem [0:255];
    logic [31:0] base_m = '0, len_m = '0;

    typedef struct { logic [31:0] pa; logic [1:0] flt; string tag; } exp_t;
    exp_t exp_q[$];

    // memory model: acknowledges one cycle after a request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
                last_rd   <= mem_addr;
                rd_cnt    <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected responses
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected response", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " R8 fault"}, {30'd0, rsp_fault}, {30'd0, e.flt});
                chk({e.tag, " R1 paddr"}, rsp_paddr, e.pa);
            end
        end
    end

    task automatic cfg_write(logic sel, logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) len_m = v; else base_m = v;
    endtask

    // driver: predicts the outcome from the requirements, then drives
    task automatic xact(string tag, logic [22:0] vpn, logic [8:0] ofs, logic wr);
        exp_t e;
        logic [31:0] ent, nent;
        logic [7:0]  idx;
        int exp_rd, exp_wr, rd0, wr0;
        idx = 8'(base_m + {9'd0, vpn});
        ent = mem[idx];
        nent = ent;
        e.tag = tag; e.pa = '0;
        exp_rd = 0; exp_wr = 0;
        if ({9'd0, vpn} >= len_m) begin
            e.flt = 2'd1;
        end else begin
            exp_rd = 1;
            if (!ent[31])               e.flt = 2'd2;
            else if (wr && ent[30])     e.flt = 2'd3;
            else begin
                e.flt = 2'd0;
                e.pa  = {ent[22:0], ofs};
                nent  = ent | 32'h2000_0000 | (wr ? 32'h1000_0000 : 32'h0);
                exp_wr = (nent != ent) ? 1 : 0;
            end
        end
        exp_q.push_back(e);
        rd0 = rd_cnt; wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = {vpn, ofs};
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10 busy"}, {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
        chk({tag, " R8 response seen"}, exp_q.size(), 0);
        chk({tag, " R2/R7 reads"}, rd_cnt - rd0, exp_rd);
        chk({tag, " R6/R7 writes"}, wr_cnt - wr0, exp_wr);
        if (exp_rd == 1) chk({tag, " R3 entry addr"}, last_rd, base_m + {9'd0, vpn});
        chk({tag, " R4/R5/R6 entry"}, mem[idx], nent);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        mem[8'h40] = 32'h8000_0000 | 32'h0012345;      // present, ref clear
        mem[8'h41] = 32'hB000_0000 | 32'h0000ABC;      // present, ref+written
        mem[8'h42] = 32'hA000_0000 | 32'h07FFFFF;      // present, ref set
        mem[8'h43] = 32'hC000_0000 | 32'h0000005;      // present, read-only
        mem[8'h44] = 32'h0000_0000 | 32'h0000777;      // absent
        mem[8'h4F] = 32'h8000_0000 | 32'h00055AA;      // last legal page
        mem[8'h90] = 32'h8000_0000 | 32'h0000002;      // after base move
        repeat (3) @(negedge clk);
        chk("R10 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R10 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R10 reset mem_req", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        cfg_write(1'b0, 32'h40);    // R11 base
        cfg_write(1'b1, 32'd16);    // R11 length
        xact("R1 R6 read sets ref",       23'd0,  9'h1A3, 1'b0);
        xact("R7 read no change",         23'd1,  9'h000, 1'b0);
        xact("R6 write sets written",     23'd2,  9'h1FF, 1'b1);
        xact("R5 write read-only",        23'd3,  9'h010, 1'b1);
        xact("R5 read read-only ok",      23'd3,  9'h010, 1'b0);
        xact("R4 absent page",            23'd4,  9'h005, 1'b0);
        xact("R4 absent page write",      23'd4,  9'h005, 1'b1);
        xact("R2 last legal page",        23'd15, 9'h000, 1'b0);
        xact("R2 page equals length",     23'd16, 9'h000, 1'b0);
        xact("R2 largest page",           23'h7FFFFF, 9'h1FF, 1'b1);
        xact("R7 repeat read",            23'd0,  9'h1A3, 1'b0);
        cfg_write(1'b0, 32'h90);
        xact("R11 R3 moved base",         23'd0,  9'h0C0, 1'b1);
        cfg_write(1'b1, 32'd0);
        xact("R11 R2 zero length",        23'd0,  9'h000, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule